// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

A synchronous behavioural static memory with two byte lanes and a parameterised depth. On every rising clock edge it decodes two cycle-start strobes, three chip enables, a burst-advance input and a set of global and per-lane write enables. From these it decides whether the edge starts a cycle, continues or suspends a burst, writes some lanes, reads the word, or deselects the device. A small burst address unit supplies the word address of each access. It follows either an interleaved (XOR) or a linear (add) four-beat order.

Read data leaves through one of two output paths, selected by a static input that is sampled only during reset. The first is a pipelined path with an extra output register. The second is a flow-through path where the data follows the registered address directly. The data bus is modelled as separate input, output and output-enable ports. The output enable follows an active-low enable input asynchronously. It is forced off after any edge that wrote. Each lane is 9 bits wide by default, with the ninth bit as parity storage, and a parameter removes that bit.

Top module: `sbsram_top`

## Requirements
- R1: While reset is low the device is deselected and `dq_oe` is low, and `pipe_sel` is captured (1 = pipelined, 0 = flow-through). Later changes of `pipe_sel` have no effect until the next reset.
- R2: When `wr_all_n` is low on a write-capable edge, every lane of the accessed word is written from `dq_in`, whatever `wr_byte_n` and `lane_we_n` are.
- R3: When `wr_all_n` is high, lane l is written only if `wr_byte_n` and `lane_we_n[l]` are both low. Lane 0 is `dq_in[LANE_W-1:0]` and lane 1 is the next LANE_W bits. If no lane is enabled, the edge is a read.
- R4: An edge with `strb_proc_n` low and `cs_main_n` low loads `addr` and starts a read. All write enables are ignored on that edge.
- R5: An edge with `strb_ctrl_n` low that is not a processor-strobe start loads `addr` and starts a cycle. The write enables sampled on that same edge decide between read and write.
- R6: On an edge with no start while the device is selected, `adv_n` low moves to the next burst address and `adv_n` high repeats the current one. The write enables are sampled on such edges.
- R7: The burst keeps the upper address bits of the loaded address. The low two bits are start XOR count when `seq_linear` is 0, and (start + count) mod 4 when it is 1.
- R8: In pipelined mode, a read accessed at edge k appears on `dq_out` with `dq_oe` high after edge k+1.
- R9: In flow-through mode, a read accessed at edge k appears after edge k.
- R10: After an edge that performed a write, `dq_oe` is low regardless of `oe_n`.
- R11: `dq_oe` is high only while `oe_n` is low and a read result is presented. It follows `oe_n` without waiting for a clock edge.
- R12: A start edge with `cs_lo_n` high or `cs_hi` low deselects the device; for a controller-strobe start `cs_main_n` high also deselects. Outputs go off one cycle later in pipelined mode and at once in flow-through mode. Continue edges while deselected neither read nor write.
- R13: `strb_proc_n` low with `cs_main_n` high starts nothing. The edge then acts as a continue edge, so a deselected device stays deselected and a selected one keeps its burst address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input except `oe_n` is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_sel | input | 1 | Output path select, captured in reset: 1 pipelined, 0 flow-through |
| seq_linear | input | 1 | Burst order: 0 interleaved, 1 linear |
| addr | input | ADDR_W | Word address loaded on a start edge |
| cs_main_n | input | 1 | Master chip enable, active low; gates the processor strobe |
| cs_lo_n | input | 1 | Secondary chip enable, active low |
| cs_hi | input | 1 | Secondary chip enable, active high |
| strb_proc_n | input | 1 | Processor-side cycle-start strobe, active low |
| strb_ctrl_n | input | 1 | Controller-side cycle-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write enable, active low |
| wr_byte_n | input | 1 | Enables the per-lane write enables, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | LANES*LANE_W | Write data |
| dq_out | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | High when `dq_out` should drive the bus |

## Verification
Every address of a 16-word configuration is first filled through controller-strobe global writes. It is then read back with processor-strobe starts in both output modes. A wrong latency shows up as the previous word or a stray high-impedance cycle. Four-beat bursts from each start offset, in both orders, separate the XOR and add sequences, and a final suspend beat must repeat the last address. Lane-masked writes, writes hidden on processor-strobe edges, deselects by each chip enable, and a blocked processor strobe during an active burst each leave a distinct mark on the stored words or on when the outputs switch off.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_t;

    // Low two address bits of burst beat 'cnt' starting at 'start'
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] cnt,
                                            input logic       lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              seq_linear,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [1:0]        cnt;
    } bst_t;

    bst_t bs_d, bs_q;
    logic [1:0] cnt_use;

    always_comb begin
        bs_d    = bs_q;
        cnt_use = step ? bs_q.cnt + 2'd1 : bs_q.cnt;
        if (load) begin
            acc_addr    = ext_addr;
            bs_d.base   = ext_addr;
            bs_d.cnt    = 2'd0;
        end else begin
            acc_addr    = {bs_q.base[ADDR_W-1:2],
                           beat_low(bs_q.base[1:0], cnt_use, seq_linear)};
            bs_d.cnt    = cnt_use;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bs_q <= '0;
        else        bs_q <= bs_d;
    end

endmodule

// File: rtl/sbsram_lane.sv
module sbsram_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter  int ADDR_W = 6,
    parameter  int LANES  = 2,
    parameter  int PARITY = 1,
    localparam int LANE_W = 8 + PARITY,
    localparam int DW     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_sel,
    input  logic              seq_linear,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_main_n,
    input  logic              cs_lo_n,
    input  logic              cs_hi,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              wr_all_n,
    input  logic              wr_byte_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              oe_n,
    input  logic [DW-1:0]     dq_in,
    output logic [DW-1:0]     dq_out,
    output logic              dq_oe
);

    typedef struct packed {
        logic              active;
        logic              wr;
        logic              rd;
        logic              rd2;
        logic              pipe;
        logic [ADDR_W-1:0] rd_addr;
        logic [DW-1:0]     dout;
    } st_t;

    st_t st_d, st_q;

    logic              proc_start, ctrl_start, any_start, sel_ok, desel_edge;
    logic [LANES-1:0]  lane_mask, lane_wr;
    logic              wants_wr, load, step;
    acc_t              acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     rd_word;

    // Edge decode
    always_comb begin
        proc_start = !strb_proc_n && !cs_main_n;
        ctrl_start = !strb_ctrl_n && !proc_start;
        any_start  = proc_start || ctrl_start;
        sel_ok     = !cs_lo_n && cs_hi && (proc_start || !cs_main_n);
        desel_edge = any_start && !sel_ok;
        for (int l = 0; l < LANES; l++)
            lane_mask[l] = !wr_all_n || (!wr_byte_n && !lane_we_n[l]);
        wants_wr = |lane_mask;

        if (proc_start)      acc = sel_ok ? ACC_READ : ACC_NONE;
        else if (ctrl_start) acc = !sel_ok ? ACC_NONE : (wants_wr ? ACC_WRITE : ACC_READ);
        else if (st_q.active) acc = wants_wr ? ACC_WRITE : ACC_READ;
        else                 acc = ACC_NONE;

        load = any_start && sel_ok;
        step = !any_start && st_q.active && !adv_n;
        for (int l = 0; l < LANES; l++)
            lane_wr[l] = (acc == ACC_WRITE) && lane_mask[l];
    end

    // Next state
    always_comb begin
        st_d         = st_q;
        st_d.active  = any_start ? sel_ok : st_q.active;
        st_d.wr      = (acc == ACC_WRITE);
        st_d.rd      = (acc == ACC_READ);
        st_d.rd2     = st_q.rd;
        st_d.rd_addr = (acc == ACC_READ) ? acc_addr : st_q.rd_addr;
        st_d.dout    = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.pipe <= pipe_sel;
        end else begin
            st_q      <= st_d;
        end
    end

    sbsram_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .seq_linear (seq_linear),
        .ext_addr   (addr),
        .acc_addr   (acc_addr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sbsram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .we      (lane_wr[l]),
            .wr_addr (acc_addr),
            .wr_data (dq_in[l*LANE_W +: LANE_W]),
            .rd_addr (st_q.rd_addr),
            .rd_data (rd_word[l*LANE_W +: LANE_W])
        );
    end

    // Output path: registered word or flow-through word
    assign dq_out = st_q.pipe ? st_q.dout : rd_word;
    assign dq_oe  = !oe_n && !st_q.wr && (st_q.pipe ? st_q.rd2 : st_q.rd);

    // R10: a write edge switches the bus off for the following cycle
    p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_WRITE) |=> !dq_oe);

    // R4: no lane is written on a processor-strobe start edge
    p_proc_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && !cs_main_n) |-> (lane_wr == '0));

    // R12: flow-through deselect turns the bus off at once
    p_desel_ft_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_edge && !st_q.pipe) |=> !dq_oe);

    // R12: pipelined deselect turns the bus off one cycle later
    p_desel_pipe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (desel_edge && st_q.pipe) |=> ##1 !dq_oe);

    // R13: a blocked processor strobe cannot select the device
    p_ce0_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_proc_n && cs_main_n && strb_ctrl_n && !st_q.active) |=> !st_q.active);

endmodule

// File: tb/sbsram_top_tb.sv
`timescale 1ns/1ps
module sbsram_top_tb_top;

    localparam int AW = 4;
    localparam int NL = 2;
    localparam int LW = 9;
    localparam int DW = NL * LW;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_sel = 1'b1;
    logic          seq_linear = 1'b0;
    logic [AW-1:0] addr;
    logic          cs_main_n, cs_lo_n, cs_hi;
    logic          strb_proc_n, strb_ctrl_n, adv_n;
    logic          wr_all_n, wr_byte_n;
    logic [NL-1:0] lane_we_n;
    logic          oe_n = 1'b0;
    logic [DW-1:0] dq_in;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [DW-1:0] ref_mem [NW];

    sbsram_top #(.ADDR_W(AW), .LANES(NL), .PARITY(1)) dut_i (
        .clk, .rst_n, .pipe_sel, .seq_linear, .addr, .cs_main_n, .cs_lo_n,
        .cs_hi, .strb_proc_n, .strb_ctrl_n, .adv_n, .wr_all_n, .wr_byte_n,
        .lane_we_n, .oe_n, .dq_in, .dq_out, .dq_oe
    );

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'(a * 1237 + salt * 311 + 77);
    endfunction

    function automatic int beat(input int start, input int j, input bit lin);
        int lo;
        lo = lin ? ((start & 3) + j) & 3 : ((start & 3) ^ j) & 3;
        return (start & ~3) | lo;
    endfunction

    task automatic dflt();
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        wr_all_n = 1'b1; wr_byte_n = 1'b1; lane_we_n = '1;
        cs_main_n = 1'b0; cs_lo_n = 1'b0; cs_hi = 1'b1;
        addr = '0; dq_in = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        dflt(); strb_ctrl_n = 1'b0; cs_main_n = 1'b1;
        tick();
    endtask

    task automatic pstart(input int a, input bit junk);
        dflt(); strb_proc_n = 1'b0; addr = AW'(a);
        if (junk) begin
            wr_all_n = 1'b0; wr_byte_n = 1'b0; lane_we_n = '0; dq_in = 18'h2A5A5;
        end
        tick();
    endtask

    task automatic cstart(input int a, input bit ga, input bit bw,
                          input logic [NL-1:0] ln, input logic [DW-1:0] d);
        dflt(); strb_ctrl_n = 1'b0; addr = AW'(a);
        wr_all_n = ga; wr_byte_n = bw; lane_we_n = ln; dq_in = d;
        tick();
    endtask

    task automatic cont(input bit adv, input bit ga, input bit bw,
                        input logic [NL-1:0] ln, input logic [DW-1:0] d);
        dflt(); adv_n = adv;
        wr_all_n = ga; wr_byte_n = bw; lane_we_n = ln; dq_in = d;
        tick();
    endtask

    task automatic chk_oe(input bit exp, input string r);
        total++;
        if (dq_oe !== exp) begin
            bad++;
            $display("FAIL %s: dq_oe=%b expected %b", r, dq_oe, exp);
        end
    endtask

    task automatic chk_rd(input logic [DW-1:0] exp, input string r);
        total++;
        if (dq_oe !== 1'b1 || dq_out !== exp) begin
            bad++;
            $display("FAIL %s: dq_oe=%b dq_out=%h expected oe=1 data=%h", r, dq_oe, dq_out, exp);
        end
    endtask

    task automatic do_reset(input bit ps);
        dflt();
        rst_n = 1'b0; pipe_sel = ps;
        repeat (3) tick();
        rst_n = 1'b1;
        #1 pipe_sel = ~ps;   // R1: ignored after reset
    endtask

    initial begin
        int e [5];
        logic [DW-1:0] d;
        dflt();
        do_reset(1'b1);
        chk_oe(1'b0, "R1");

        // Global writes through controller strobe, all addresses
        for (int a = 0; a < NW; a++) begin
            cstart(a, 1'b0, 1'b1, 2'b11, pat(a, 1));
            ref_mem[a] = pat(a, 1);
            chk_oe(1'b0, "R10");
        end
        idle();

        // Pipelined reads via processor strobe, write enables asserted as junk
        for (int a = 0; a < NW; a++) begin
            idle();
            pstart(a, 1'b1);
            chk_oe(1'b0, "R8");          // not yet presented
            cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
            chk_rd(ref_mem[a], "R4_R8");
        end
        idle(); idle();

        // Bursts in both orders from every start offset
        for (int lin = 0; lin < 2; lin++) begin
            for (int b = 0; b < 4; b++) begin
                seq_linear = lin[0];
                for (int j = 0; j < 4; j++) e[j] = beat(8 + b, j, lin[0]);
                e[4] = e[3];
                pstart(8 + b, 1'b0);
                for (int j = 1; j <= 3; j++) begin
                    cont(1'b0, 1'b1, 1'b1, 2'b11, '0);
                    chk_rd(ref_mem[e[j-1]], "R7");
                end
                cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
                chk_rd(ref_mem[e[3]], "R6");
                idle();
                chk_rd(ref_mem[e[4]], "R6");
                idle();
                chk_oe(1'b0, "R12");
            end
        end
        seq_linear = 1'b0;

        // Lane writes
        d = 18'h3C3C3;
        cstart(5, 1'b1, 1'b0, 2'b10, d);
        ref_mem[5] = {ref_mem[5][DW-1:LW], d[LW-1:0]};
        chk_oe(1'b0, "R3");
        cstart(6, 1'b1, 1'b0, 2'b01, d);
        ref_mem[6] = {d[DW-1:LW], ref_mem[6][LW-1:0]};
        cstart(9, 1'b0, 1'b0, 2'b10, d);
        ref_mem[9] = d;
        cstart(7, 1'b1, 1'b1, 2'b00, d);          // lane enables without wr_byte_n: read
        chk_oe(1'b0, "R3");
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        chk_rd(ref_mem[7], "R3_R5");
        idle(); idle();
        for (int a = 5; a <= 9; a++) begin
            pstart(a, 1'b0);
            cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
            chk_rd(ref_mem[a], "R2_R3");
            idle();
        end

        // Burst write: start, advance, suspend
        cstart(12, 1'b0, 1'b1, 2'b11, pat(12, 5));
        ref_mem[12] = pat(12, 5);
        cont(1'b0, 1'b0, 1'b1, 2'b11, pat(13, 5));
        cont(1'b1, 1'b0, 1'b1, 2'b11, pat(13, 6));
        ref_mem[13] = pat(13, 6);
        idle();
        for (int a = 12; a <= 14; a++) begin
            pstart(a, 1'b0);
            cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
            chk_rd(ref_mem[a], "R6");
            idle();
        end

        // Asynchronous output enable
        pstart(2, 1'b0);
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        #3 oe_n = 1'b1; #1;
        chk_oe(1'b0, "R11");
        #1 oe_n = 1'b0; #1;
        chk_rd(ref_mem[2], "R11");

        // Deselect by secondary enable on a processor start
        dflt(); strb_proc_n = 1'b0; cs_lo_n = 1'b1; addr = 4'd4;
        tick();
        chk_rd(ref_mem[2], "R12");      // previous read still shown one cycle
        cont(1'b0, 1'b0, 1'b1, 2'b11, 18'h11111);   // must not write
        chk_oe(1'b0, "R12");
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        chk_oe(1'b0, "R12");
        for (int a = 2; a <= 4; a++) begin
            idle();
            pstart(a, 1'b0);
            cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
            chk_rd(ref_mem[a], "R12");
        end
        // Deselect by controller strobe with cs_hi low
        dflt(); strb_ctrl_n = 1'b0; cs_hi = 1'b0; tick();
        chk_rd(ref_mem[4], "R12");
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        chk_oe(1'b0, "R12");

        // Blocked processor strobe while deselected
        idle();
        dflt(); strb_proc_n = 1'b0; cs_main_n = 1'b1; addr = 4'd1; tick();
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        chk_oe(1'b0, "R13");
        // Blocked processor strobe during an active burst keeps the old address
        pstart(10, 1'b0);
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        dflt(); strb_proc_n = 1'b0; cs_main_n = 1'b1; addr = 4'd11; tick();
        chk_rd(ref_mem[10], "R13");
        cont(1'b1, 1'b1, 1'b1, 2'b11, '0);
        chk_rd(ref_mem[10], "R13");
        idle(); idle();

        // Flow-through mode
        do_reset(1'b0);
        chk_oe(1'b0, "R1");
        for (int a = 0; a < NW; a++) begin
            idle();
            pstart(a, a[0]);
            chk_rd(ref_mem[a], "R9_R4");
        end
        seq_linear = 1'b1;
        pstart(6, 1'b0);
        chk_rd(ref_mem[6], "R9");
        cont(1'b0, 1'b1, 1'b1, 2'b11, '0);
        chk_rd(ref_mem[7], "R7_R9");
        cont(1'b0, 1'b1, 1'b1, 2'b11, '0);
        chk_rd(ref_mem[4], "R7_R9");
        dflt(); strb_proc_n = 1'b0; cs_hi = 1'b0; addr = 4'd3; tick();
        chk_oe(1'b0, "R12");
        cstart(0, 1'b0, 1'b1, 2'b11, pat(0, 9));
        ref_mem[0] = pat(0, 9);
        chk_oe(1'b0, "R10");
        pstart(0, 1'b0);
        chk_rd(ref_mem[0], "R1_R9");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule